// File: doc/BRIEF.md
# Misaligned Load/Store Bus Splitter

This block sits between a load/store unit and a 64-bit big-endian data bus. It takes one request: a byte address, an operand size of 1, 2, 4 or 8 bytes, a direction and a right-justified write operand. It turns the request into one, two or three bus transactions. Each transaction carries the full address of its first byte, a 3-bit transfer-size code and an 8-bit mask with one bit per byte lane. The block places write bytes on the correct lanes and collects read bytes from the lanes into one right-justified operand.

An access that fits inside one 32-bit word goes out as one transaction, even when it is misaligned. An aligned double-word also goes out as one transaction. Any other access is cut at each word boundary into pieces, and the pieces are issued in ascending address order. The requester sees a single response after the last piece is acknowledged.

The control is a four-state machine:
- ST_IDLE: ready for a request. It moves to ST_ISSUE on "accept" (valid and ready both high).
- ST_ISSUE: a one-cycle start pulse. It always moves to ST_WAIT ("launch").
- ST_WAIT: the transaction is held on the bus. On an acknowledge it moves back to ST_ISSUE ("next piece") if bytes remain, or to ST_RESP ("final ack") if none remain.
- ST_RESP: a one-cycle response. It always returns to ST_IDLE ("retire").

Top module: `lsu_bus_splitter`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the cycle after acceptance until the response has been given.
- R2: An access whose bytes all lie in one 32-bit word is issued as exactly one transaction. An 8-byte access at a low address of 000 is also issued as exactly one transaction.
- R3: Any other access is split at 32-bit word boundaries. The first piece runs from the start address to the end of its word, and each later piece starts at the next word address. Pieces are issued in ascending address order, so a misaligned 8-byte access takes two or three transactions.
- R4: `bus_tsize` is the byte count of the piece for 1 to 4 bytes (001, 010, 011, 100) and 000 for a full 8-byte piece.
- R5: `bus_addr` is the address of the piece's first byte. Bit n of `bus_lanes` enables lane n, and lane n is the byte whose low three address bits equal n. The mask covers exactly the piece's bytes.
- R6: On a write, the byte at the lowest address is the most significant byte of the right-justified operand, and lane n travels on `bus_wdata[63-8n -: 8]`.
- R7: On a read, the selected lanes of all pieces are merged big-endian into a right-justified `rsp_rdata` whose unused upper bytes are zero. Data on lanes that are not selected has no effect.
- R8: `bus_start` is a one-cycle pulse, one cycle after acceptance or after the previous piece's `bus_ack`. The bus outputs hold steady until `bus_ack`. `rsp_valid` is a one-cycle pulse in the cycle after the final `bus_ack`.
- R9: After reset, `req_ready` is 1 and `bus_start` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | log2 of operand bytes (0..3) |
| req_wdata | input | 64 | Right-justified store operand |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | 64 | Right-justified load result |
| bus_start | output | 1 | Transaction start pulse |
| bus_we | output | 1 | Transaction direction |
| bus_addr | output | 32 | Address of the piece's first byte |
| bus_tsize | output | 3 | Transfer-size code |
| bus_lanes | output | 8 | Byte-lane enables, bit n = lane n |
| bus_wdata | output | 64 | Lane-steered write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | 64 | Lane read data |

## Verification
The byte cursor and the done-byte counter are the internal state that matters. If the cursor is wrong, the very next start pulse shows a mask, size code or address that disagrees with the word-boundary rule. If the counter is wrong, the piece count changes or a read byte lands in the wrong operand position, and this shows at the response a few cycles later. A state-machine fault shows at once as a start pulse longer than one cycle, a ready during a busy period, or a response that does not follow an acknowledge. Sweeping every low-address and size pair with a write and a read-back through a byte memory exposes each of these within the access that triggers it.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } split_state_e;

    // Operand byte (counted from the LSB) that a lane carries in the current piece
    function automatic int opnd_byte_of_lane(int op_bytes, int done_bytes, int cur_off, int lane);
        return op_bytes - 1 - (done_bytes + lane - cur_off);
    endfunction

    // Lane that carries a given operand byte (counted from the LSB) in the current piece
    function automatic int lane_of_opnd_byte(int op_bytes, int done_bytes, int cur_off, int obyte);
        return cur_off + (op_bytes - 1 - obyte) - done_bytes;
    endfunction

endpackage

// File: rtl/lsu_piece_plan.sv
module lsu_piece_plan #(
    parameter  int LANES   = 8,
    parameter  int WORD_B  = 4,
    localparam int LANE_W  = $clog2(LANES),
    localparam int CNT_W   = LANE_W + 1,
    localparam int WORD_SH = $clog2(WORD_B)
) (
    input  logic [LANE_W-1:0] cur_off,
    input  logic [CNT_W-1:0]  remain,
    output logic [CNT_W-1:0]  piece_len,
    output logic [LANE_W-1:0] tsize,
    output logic [LANES-1:0]  lanes
);

    logic [CNT_W-1:0] room;

    always_comb begin
        // bytes left before the next word boundary
        room = CNT_W'(WORD_B) - CNT_W'(cur_off[WORD_SH-1:0]);
        if (remain == CNT_W'(LANES) && cur_off == '0) begin
            piece_len = CNT_W'(LANES);
        end else if (remain < room) begin
            piece_len = remain;
        end else begin
            piece_len = room;
        end
        tsize = (piece_len == CNT_W'(LANES)) ? '0 : piece_len[LANE_W-1:0];
        for (int n = 0; n < LANES; n++) begin
            lanes[n] = (n >= int'(cur_off)) && (n < int'(cur_off) + int'(piece_len));
        end
    end

endmodule

// File: rtl/lsu_wr_steer.sv
module lsu_wr_steer
    import lsu_split_pkg::*;
#(
    parameter  int LANES  = 8,
    localparam int DW     = LANES * 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int CNT_W  = LANE_W + 1
) (
    input  logic [DW-1:0]     operand,
    input  logic [CNT_W-1:0]  op_bytes,
    input  logic [CNT_W-1:0]  done_bytes,
    input  logic [LANE_W-1:0] cur_off,
    input  logic [LANES-1:0]  lanes,
    output logic [DW-1:0]     lane_data
);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        int                src;
        logic [LANE_W-1:0] src_sel;
        logic              in_range;

        assign src      = opnd_byte_of_lane(int'(op_bytes), int'(done_bytes), int'(cur_off), n);
        assign in_range = (src >= 0) && (src < LANES);
        assign src_sel  = src[LANE_W-1:0];
        assign lane_data[DW-1-8*n -: 8] = (lanes[n] && in_range) ?
                                          operand[8*int'(src_sel) +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsu_rd_gather.sv
module lsu_rd_gather
    import lsu_split_pkg::*;
#(
    parameter  int LANES  = 8,
    localparam int DW     = LANES * 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int CNT_W  = LANE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [DW-1:0]     bus_rdata,
    input  logic [LANES-1:0]  lanes,
    input  logic [LANE_W-1:0] cur_off,
    input  logic [CNT_W-1:0]  op_bytes,
    input  logic [CNT_W-1:0]  done_bytes,
    output logic [DW-1:0]     result
);

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        int                ln;
        logic [LANE_W-1:0] ln_sel;
        logic              hit;
        logic [7:0]        acc_q;

        assign ln     = lane_of_opnd_byte(int'(op_bytes), int'(done_bytes), int'(cur_off), b);
        assign ln_sel = ln[LANE_W-1:0];
        assign hit    = capture && (ln >= 0) && (ln < LANES) && lanes[ln_sel];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= 8'h00;
            end else if (clear) begin
                acc_q <= 8'h00;
            end else if (hit) begin
                acc_q <= bus_rdata[DW-1-8*int'(ln_sel) -: 8];
            end
        end

        assign result[8*b +: 8] = acc_q;
    end

endmodule

// File: rtl/lsu_bus_splitter.sv
module lsu_bus_splitter
    import lsu_split_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int LANES  = 8,
    parameter  int WORD_B = 4,
    localparam int DW     = LANES * 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int SZ_W   = $clog2(LANE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              bus_start,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANE_W-1:0] bus_tsize,
    output logic [LANES-1:0]  bus_lanes,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic [DW-1:0]     bus_rdata
);

    localparam int CNT_W = LANE_W + 1;

    split_state_e      state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  done_q;
    logic [CNT_W-1:0]  total_q;
    logic              we_q;
    logic [DW-1:0]     wdata_q;

    logic              accept;
    logic              acked;
    logic              last_piece;
    logic [CNT_W-1:0]  remain;
    logic [CNT_W-1:0]  piece_len;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign acked      = (state_q == ST_WAIT) && bus_ack;
    assign remain     = total_q - done_q;
    assign last_piece = (done_q + piece_len) == total_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (bus_ack) state_d = last_piece ? ST_RESP : ST_ISSUE;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        bus_start = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: bus_start = 1'b1;
            ST_WAIT:  ;
            ST_RESP:  rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    // request context and byte cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            done_q     <= '0;
            total_q    <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
        end else if (accept) begin
            cur_addr_q <= req_addr;
            done_q     <= '0;
            total_q    <= CNT_W'(1) << req_size;
            we_q       <= req_we;
            wdata_q    <= req_wdata;
        end else if (acked) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(piece_len);
            done_q     <= done_q + piece_len;
        end
    end

    lsu_piece_plan #(
        .LANES  (LANES),
        .WORD_B (WORD_B)
    ) plan_i (
        .cur_off   (cur_addr_q[LANE_W-1:0]),
        .remain    (remain),
        .piece_len (piece_len),
        .tsize     (bus_tsize),
        .lanes     (bus_lanes)
    );

    lsu_wr_steer #(
        .LANES (LANES)
    ) steer_i (
        .operand    (wdata_q),
        .op_bytes   (total_q),
        .done_bytes (done_q),
        .cur_off    (cur_addr_q[LANE_W-1:0]),
        .lanes      (bus_lanes),
        .lane_data  (bus_wdata)
    );

    lsu_rd_gather #(
        .LANES (LANES)
    ) gather_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    (acked && !we_q),
        .bus_rdata  (bus_rdata),
        .lanes      (bus_lanes),
        .cur_off    (cur_addr_q[LANE_W-1:0]),
        .op_bytes   (total_q),
        .done_bytes (done_q),
        .result     (rsp_rdata)
    );

    assign bus_addr = cur_addr_q;
    assign bus_we   = we_q;

endmodule

// File: rtl/lsu_bus_splitter_chk.sv
module lsu_bus_splitter_chk #(
    parameter  int ADDR_W  = 32,
    parameter  int LANES   = 8,
    parameter  int WORD_B  = 4,
    localparam int LANE_W  = $clog2(LANES),
    localparam int WORD_SH = $clog2(WORD_B)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              bus_start,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANE_W-1:0] bus_tsize,
    input logic [LANES-1:0]  bus_lanes,
    input logic              bus_ack
);

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> !req_ready);

    a_r2_piece_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_tsize != '0) |->
        (int'(bus_addr[WORD_SH-1:0]) + int'(bus_tsize)) <= WORD_B);

    a_r2_full_piece_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_tsize == '0) |-> bus_addr[LANE_W-1:0] == '0);

    a_r4_size_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> $countones(bus_lanes) == ((bus_tsize == '0) ? LANES : int'(bus_tsize)));

    a_r5_first_lane_set: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> bus_lanes[bus_addr[LANE_W-1:0]]);

    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    a_r8_hold_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> ($stable(bus_addr) && $stable(bus_lanes) && $stable(bus_tsize)));

    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_ack));

endmodule

bind lsu_bus_splitter lsu_bus_splitter_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .WORD_B (WORD_B)
) chk_i (.*);

// File: tb/lsu_bus_splitter_tb_top.sv
`timescale 1ns/100ps
module lsu_bus_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_we;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        bus_start;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [2:0]  bus_tsize;
    logic [7:0]  bus_lanes;
    logic [63:0] bus_wdata;
    logic        bus_ack;
    logic [63:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]  mem [0:1023];
    int          n_tx;
    logic [31:0] tx_addr  [4];
    logic [7:0]  tx_lanes [4];
    logic [2:0]  tx_tsize [4];
    logic        tx_we    [4];
    int          dly_sel = 0;

    always #2.5 clk = ~clk;

    lsu_bus_splitter dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
        .req_addr (req_addr), .req_size (req_size), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .bus_start (bus_start), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_tsize (bus_tsize), .bus_lanes (bus_lanes), .bus_wdata (bus_wdata),
        .bus_ack (bus_ack), .bus_rdata (bus_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bus memory model: sees start at negedge, acks after a varying delay
    initial begin
        bus_ack   = 1'b0;
        bus_rdata = '0;
        n_tx      = 0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (rst_n && bus_start) begin
                if (n_tx < 4) begin
                    tx_addr[n_tx]  = bus_addr;
                    tx_lanes[n_tx] = bus_lanes;
                    tx_tsize[n_tx] = bus_tsize;
                    tx_we[n_tx]    = bus_we;
                end
                n_tx++;
                for (int l = 0; l < 8; l++) begin
                    logic [9:0] a;
                    a = {bus_addr[9:3], 3'(l)};
                    if (bus_lanes[l] && bus_we) mem[a] = bus_wdata[63-8*l -: 8];
                    // unselected lanes carry junk that must be ignored (R7)
                    bus_rdata[63-8*l -: 8] = bus_lanes[l] ? mem[a] : (8'hA5 ^ 8'(l));
                end
                @(negedge clk);
                check(bus_start == 1'b0, "R8", "start pulse width", 64'(bus_start), 64'd0);
                repeat (dly_sel % 3) @(negedge clk);
                dly_sel++;
                bus_ack = 1'b1;
            end
        end
    end

    // one access: drive, wait for response, compare pieces and data
    task automatic do_access(input logic [31:0] addr, input int size, input bit we,
                             input logic [63:0] data);
        int          nb;
        int          np;
        int          t;
        logic [31:0] ea [4];
        logic [7:0]  el [4];
        int          ec [4];
        logic [63:0] mask;
        nb   = 1 << size;
        mask = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 1);
        np   = 0;
        if (nb == 8 && addr[2:0] == 3'd0) begin
            np = 1; ea[0] = addr; el[0] = 8'hFF; ec[0] = 8;
        end else begin
            for (int i = 0; i < nb; i++) begin
                logic [31:0] b;
                b = addr + 32'(i);
                if (i == 0 || b[1:0] == 2'd0) begin
                    ea[np] = b; el[np] = 8'h00; ec[np] = 0; np++;
                end
                el[np-1][b[2:0]] = 1'b1;
                ec[np-1]++;
            end
        end
        n_tx = 0;
        @(negedge clk);
        req_addr  = addr;
        req_size  = 2'(size);
        req_we    = we;
        req_wdata = data & mask;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
        check(bus_start == 1'b1, "R8", "start after accept", 64'(bus_start), 64'd1);
        t = 0;
        while (!rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        check(rsp_valid == 1'b1, "R8", "response seen", 64'(rsp_valid), 64'd1);
        check(n_tx == np, (np == 1) ? "R2" : "R3", "transaction count", 64'(n_tx), 64'(np));
        for (int p = 0; p < np && p < n_tx; p++) begin
            logic [2:0] et;
            et = (ec[p] == 8) ? 3'd0 : 3'(ec[p]);
            check(tx_addr[p] == ea[p], "R3", "piece address", 64'(tx_addr[p]), 64'(ea[p]));
            check(tx_lanes[p] == el[p], "R5", "lane mask", 64'(tx_lanes[p]), 64'(el[p]));
            check(tx_tsize[p] == et, "R4", "size code", 64'(tx_tsize[p]), 64'(et));
            check(tx_we[p] == we, "R8", "bus direction", 64'(tx_we[p]), 64'(we));
        end
        if (we) begin
            for (int i = 0; i < nb; i++) begin
                logic [9:0] a;
                logic [7:0] eb;
                a  = 10'(addr + 32'(i));
                eb = data[8*(nb-1-i) +: 8];
                check(mem[a] == eb, "R6", "stored byte", 64'(mem[a]), 64'(eb));
            end
        end else begin
            check(rsp_rdata == (data & mask), "R7", "load result", rsp_rdata, data & mask);
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "response pulse width", 64'(rsp_valid), 64'd0);
    endtask

    task automatic test_reset_state();
        check(req_ready == 1'b1, "R9", "reset ready", 64'(req_ready), 64'd1);
        check(bus_start == 1'b0, "R9", "reset start", 64'(bus_start), 64'd0);
        check(rsp_valid == 1'b0, "R9", "reset response", 64'(rsp_valid), 64'd0);
    endtask

    // every low-address offset for one size, store then load back
    task automatic test_size_sweep(input int size);
        for (int off = 0; off < 8; off++) begin
            logic [63:0] d;
            logic [31:0] a;
            d = {$urandom, $urandom};
            a = 32'h100 + 32'(size * 64) + 32'(off);
            do_access(a, size, 1'b1, d);
            do_access(a, size, 1'b0, d);
        end
    endtask

    // named corner cases: in-word odd half-word, triple-piece double-word
    task automatic test_corners();
        do_access(32'h201, 1, 1'b1, 64'h0000_0000_0000_BEEF); // R2 single piece
        do_access(32'h201, 1, 1'b0, 64'h0000_0000_0000_BEEF);
        do_access(32'h30B, 3, 1'b1, 64'h1122_3344_5566_7788); // R3 three pieces
        do_access(32'h30B, 3, 1'b0, 64'h1122_3344_5566_7788);
        do_access(32'h307, 1, 1'b1, 64'h0000_0000_0000_A1B2); // R3 crosses doubleword
        do_access(32'h307, 1, 1'b0, 64'h0000_0000_0000_A1B2);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_we    = 1'b0;
        req_addr  = '0;
        req_size  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        for (int s = 0; s < 4; s++) test_size_sweep(s);
        test_corners();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule